// File: doc/BRIEF.md
# Per-Lane Vector Byte Shifter

This block shifts a wide vector by whole bytes, treating each 128-bit lane as its own independent register. An immediate sets the byte count and a direction input picks left or right. Vacated byte positions are filled with zeros. A byte that leaves one lane is dropped; it never enters the lane next to it. The datapath has no registers. The result follows the inputs within the same cycle.

A narrow-mode input reuses the same datapath for a single-lane (128-bit) operation. In that mode only lane 0 is computed and every higher lane reads zero.

A small decoder sits beside the datapath. It recognises the two wide byte-shift instruction words and extracts their immediate and register fields. An issue stage can then steer those fields into the shifter.

Top module: `vbs_lane_shifter`

## Requirements
- R1: The byte count is the low four bits of `shamt_imm` (0 to 15 bytes). Bit 4 of `shamt_imm` has no effect on `res_vec`.
- R2: For a left shift (`shift_right` = 0) by s bytes, byte i of each active lane takes source byte i-s of the same lane when i >= s. Bytes 0 to s-1 of the lane are zero.
- R3: For a right shift (`shift_right` = 1) by s bytes, byte i of each active lane takes source byte i+s of the same lane when i+s <= 15. The top s bytes of the lane are zero.
- R4: Lanes are shifted independently. No byte moves from one 128-bit lane into another, in either direction.
- R5: A byte count of zero passes every active lane through unchanged.
- R6: When `narrow_mode` = 1, lane 0 (bits 127:0) is shifted as usual and all higher lanes of `res_vec` are zero.
- R7: For a byte count of 8 or more, the 64-bit half of a lane that receives data holds only bytes taken from the other 64-bit half of that lane, and the other half is all zero.
- R8: `insn_is_bshift` is 1 exactly when `insn_word[31:15]` equals 17'b0111_0110_1000_11100 (left form) or 17'b0111_0110_1000_11101 (right form). `insn_right` equals `insn_word[15]`. `insn_imm` is `insn_word[14:10]`, `insn_src` is `insn_word[9:5]` and `insn_dst` is `insn_word[4:0]`.
- R9: Any other instruction word gives `insn_is_bshift` = 0 and `insn_right` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_vec | input | 256 | Source vector, byte 0 in bits 7:0 |
| shamt_imm | input | 5 | Immediate; low four bits give the byte count |
| shift_right | input | 1 | 0 shifts toward higher bytes, 1 toward lower bytes |
| narrow_mode | input | 1 | 1 computes lane 0 only and zeros the higher lanes |
| insn_word | input | 32 | Instruction word to classify |
| res_vec | output | 256 | Shifted result |
| insn_is_bshift | output | 1 | Word is one of the two wide byte-shift forms |
| insn_right | output | 1 | Recognised form is the right shift |
| insn_imm | output | 5 | Immediate field of the word |
| insn_dst | output | 5 | Destination register field |
| insn_src | output | 5 | Source register field |

## Verification
The decoder and the shift datapath work at the same time on unrelated inputs. A fault could let one of them take its control from the other. The bench therefore applies instruction words whose immediate and direction fields disagree with `shamt_imm` and `shift_right`. It then checks that `res_vec` follows only the data-path controls and that the decoded fields follow only the word. Narrow mode and lane isolation also fall in the same evaluation. An exhaustive sweep over every immediate, both directions and both widths compares each byte against a byte-loop model.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned INSN_W    = 32;

   // Major opcode shared by both forms, bits 31:16 of the word.
   localparam logic [15:0] BSHIFT_MAJOR = 16'b0111_0110_1000_1110;

   typedef enum logic [0:0] {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } shift_dir_e;

   typedef enum int unsigned {
      IMPL_LOG_STAGES = 0,
      IMPL_BYTE_MUX   = 1
   } shift_impl_e;

   typedef struct packed {
      logic       hit;
      shift_dir_e dir;
      logic [4:0] imm;
      logic [4:0] src;
      logic [4:0] dst;
   } bshift_fields_t;
endpackage

// File: rtl/vbs_decode.sv
module vbs_decode
   import vbs_pkg::*;
(
   input  logic [INSN_W-1:0] word_i,
   output bshift_fields_t    fields_o
);
   logic major_ok;

   always_comb begin
      major_ok         = (word_i[31:16] == BSHIFT_MAJOR);
      fields_o.hit     = major_ok;
      fields_o.dir     = (major_ok && word_i[15]) ? DIR_RIGHT : DIR_LEFT;
      fields_o.imm     = word_i[14:10];
      fields_o.src     = word_i[9:5];
      fields_o.dst     = word_i[4:0];
   end
endmodule

// File: rtl/vbs_lane_shift.sv
module vbs_lane_shift
   import vbs_pkg::*;
#(
   parameter int unsigned LANE_W  = 128,
   parameter int unsigned SHAMT_W = 4,
   parameter int unsigned IMPL    = IMPL_LOG_STAGES
) (
   input  logic [LANE_W-1:0]  lane_i,
   input  logic [SHAMT_W-1:0] count_i,
   input  shift_dir_e         dir_i,
   output logic [LANE_W-1:0]  lane_o
);
   localparam int unsigned NBYTES = LANE_W / BYTE_BITS;

   if (IMPL == IMPL_LOG_STAGES) begin : g_log
      logic [LANE_W-1:0] stage [SHAMT_W+1];
      assign stage[0] = lane_i;
      for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
         localparam int unsigned STEP = BYTE_BITS << k;
         always_comb begin
            if (!count_i[k])
               stage[k+1] = stage[k];
            else if (dir_i == DIR_RIGHT)
               stage[k+1] = stage[k] >> STEP;
            else
               stage[k+1] = stage[k] << STEP;
         end
      end
      assign lane_o = stage[SHAMT_W];
   end else begin : g_mux
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         always_comb begin
            lane_o[i*BYTE_BITS +: BYTE_BITS] = '0;
            for (int j = 0; j < NBYTES; j++) begin
               if (dir_i == DIR_RIGHT) begin
                  if (j == i + int'(count_i))
                     lane_o[i*BYTE_BITS +: BYTE_BITS] = lane_i[j*BYTE_BITS +: BYTE_BITS];
               end else begin
                  if (j + int'(count_i) == i)
                     lane_o[i*BYTE_BITS +: BYTE_BITS] = lane_i[j*BYTE_BITS +: BYTE_BITS];
               end
            end
         end
      end
   end
endmodule

// File: rtl/vbs_lane_shifter.sv
module vbs_lane_shifter
   import vbs_pkg::*;
#(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned LANE_W  = 128,
   parameter int unsigned IMM_W   = 5,
   parameter int unsigned SHAMT_W = 4,
   parameter int unsigned IMPL    = IMPL_LOG_STAGES
) (
   input  logic [DATA_W-1:0] src_vec,
   input  logic [IMM_W-1:0]  shamt_imm,
   input  logic              shift_right,
   input  logic              narrow_mode,
   input  logic [31:0]       insn_word,
   output logic [DATA_W-1:0] res_vec,
   output logic              insn_is_bshift,
   output logic              insn_right,
   output logic [4:0]        insn_imm,
   output logic [4:0]        insn_dst,
   output logic [4:0]        insn_src
);
   localparam int unsigned NLANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a whole number of lanes");
   end
   if ((LANE_W / BYTE_BITS) != (1 << SHAMT_W)) begin : g_bad_shamt
      $error("SHAMT_W must index every byte of a lane");
   end
   if (IMM_W <= SHAMT_W) begin : g_bad_imm
      $error("IMM_W must be wider than SHAMT_W");
   end

   logic [SHAMT_W-1:0] count;
   shift_dir_e         dir;
   assign count = shamt_imm[SHAMT_W-1:0];
   assign dir   = shift_right ? DIR_RIGHT : DIR_LEFT;

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      logic [LANE_W-1:0] shifted;
      vbs_lane_shift #(
         .LANE_W (LANE_W),
         .SHAMT_W(SHAMT_W),
         .IMPL   (IMPL)
      ) u_shift (
         .lane_i (src_vec[l*LANE_W +: LANE_W]),
         .count_i(count),
         .dir_i  (dir),
         .lane_o (shifted)
      );
      if (l == 0) begin : g_low
         assign res_vec[l*LANE_W +: LANE_W] = shifted;
      end else begin : g_high
         assign res_vec[l*LANE_W +: LANE_W] = narrow_mode ? '0 : shifted;
      end
   end

   bshift_fields_t fields;
   vbs_decode u_decode (
      .word_i  (insn_word),
      .fields_o(fields)
   );

   assign insn_is_bshift = fields.hit;
   assign insn_right     = (fields.dir == DIR_RIGHT);
   assign insn_imm       = fields.imm;
   assign insn_dst       = fields.dst;
   assign insn_src       = fields.src;
endmodule

// File: rtl/vbs_lane_shifter_chk.sv
module vbs_lane_shifter_chk #(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned LANE_W  = 128,
   parameter int unsigned IMM_W   = 5,
   parameter int unsigned SHAMT_W = 4
) (
   input logic [DATA_W-1:0] src_vec,
   input logic [IMM_W-1:0]  shamt_imm,
   input logic              shift_right,
   input logic              narrow_mode,
   input logic [31:0]       insn_word,
   input logic [DATA_W-1:0] res_vec,
   input logic              insn_is_bshift,
   input logic              insn_right,
   input logic [4:0]        insn_imm,
   input logic [4:0]        insn_dst,
   input logic [4:0]        insn_src
);
   localparam int NB = LANE_W / 8;
   localparam int NL = DATA_W / LANE_W;

   logic zero_ok, left_ok, right_ok, narrow_ok;

   always_comb begin
      int s;
      logic act;
      logic [7:0] rb, sb;
      s = int'(shamt_imm[SHAMT_W-1:0]);
      zero_ok = 1'b1; left_ok = 1'b1; right_ok = 1'b1; narrow_ok = 1'b1;
      for (int l = 0; l < NL; l++) begin
         act = !narrow_mode || (l == 0);
         for (int b = 0; b < NB; b++) begin
            rb = res_vec[l*LANE_W + b*8 +: 8];
            sb = src_vec[l*LANE_W + b*8 +: 8];
            if (act && s == 0 && rb != sb) zero_ok = 1'b0;
            if (act && !shift_right && b < s && rb != 8'h00) left_ok = 1'b0;
            if (act && shift_right && b >= NB - s && rb != 8'h00) right_ok = 1'b0;
            if (!act && rb != 8'h00) narrow_ok = 1'b0;
         end
      end
   end

   always_comb begin
      p_zero_pass_r5: assert (zero_ok);
      p_left_fill_r2: assert (left_ok);
      p_right_fill_r3: assert (right_ok);
      p_narrow_hi_zero_r6: assert (narrow_ok);
      p_decode_major_r8: assert (!insn_is_bshift || insn_word[31:16] == 16'h768E);
      p_right_needs_hit_r9: assert (!insn_right || insn_is_bshift);
   end
endmodule

bind vbs_lane_shifter vbs_lane_shifter_chk #(
   .DATA_W (DATA_W),
   .LANE_W (LANE_W),
   .IMM_W  (IMM_W),
   .SHAMT_W(SHAMT_W)
) u_chk (.*);

// File: tb/vbs_lane_shifter_bench.sv
module vbs_lane_shifter_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DW = 256;
   localparam int  LW = 128;
   localparam int  NB = LW / 8;

   logic          clk = 1'b0;
   logic [DW-1:0] src_vec = '0;
   logic [4:0]    shamt_imm = '0;
   logic          shift_right = 1'b0;
   logic          narrow_mode = 1'b0;
   logic [31:0]   insn_word = '0;
   logic [DW-1:0] res_vec;
   logic          insn_is_bshift, insn_right;
   logic [4:0]    insn_imm, insn_dst, insn_src;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vbs_lane_shifter u_vbs_lane_shifter (
      .src_vec(src_vec), .shamt_imm(shamt_imm), .shift_right(shift_right),
      .narrow_mode(narrow_mode), .insn_word(insn_word), .res_vec(res_vec),
      .insn_is_bshift(insn_is_bshift), .insn_right(insn_right),
      .insn_imm(insn_imm), .insn_dst(insn_dst), .insn_src(insn_src)
   );

   function automatic logic [DW-1:0] model(input logic [DW-1:0] s, input logic [4:0] imm,
                                           input logic rt, input logic nar);
      logic [DW-1:0] r;
      int c;
      r = '0;
      c = int'(imm[3:0]);
      for (int l = 0; l < DW / LW; l++) begin
         if (nar && l != 0) continue;
         for (int i = 0; i < NB; i++) begin
            if (rt) begin
               if (i + c < NB) r[l*LW + i*8 +: 8] = s[l*LW + (i+c)*8 +: 8];
            end else begin
               if (i >= c) r[l*LW + i*8 +: 8] = s[l*LW + (i-c)*8 +: 8];
            end
         end
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] pattern(input int seed);
      logic [DW-1:0] p;
      for (int b = 0; b < DW / 8; b++) p[b*8 +: 8] = 8'((seed + b * 37 + 1) ^ (b << 3));
      return p;
   endfunction

   task automatic apply(input logic [DW-1:0] s, input logic [4:0] imm, input logic rt,
                        input logic nar);
      @(posedge clk);
      src_vec = s; shamt_imm = imm; shift_right = rt; narrow_mode = nar;
      @(negedge clk);
   endtask

   task automatic check_vec(input string req, input logic [DW-1:0] exp);
      n_checks++;
      if (res_vec !== exp) begin
         n_fails++;
         $display("FAIL %s: res_vec=%h expected=%h", req, res_vec, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic t_idle();
      @(negedge clk);
      check_vec("R5 idle zero", '0);
      check_bit("R9 idle decode", insn_is_bshift, 1'b0);
   endtask

   task automatic t_zero_shift();
      logic [DW-1:0] p;
      p = pattern(3);
      apply(p, 5'd0, 1'b0, 1'b0); check_vec("R5 left zero", p);
      apply(p, 5'd0, 1'b1, 1'b0); check_vec("R5 right zero", p);
   endtask

   task automatic t_left_right();
      logic [DW-1:0] p;
      p = pattern(11);
      apply(p, 5'd1, 1'b0, 1'b0);  check_vec("R2 left 1", model(p, 5'd1, 1'b0, 1'b0));
      apply(p, 5'd5, 1'b0, 1'b0);  check_vec("R2 left 5", model(p, 5'd5, 1'b0, 1'b0));
      apply(p, 5'd15, 1'b0, 1'b0); check_vec("R2 left 15", model(p, 5'd15, 1'b0, 1'b0));
      apply(p, 5'd3, 1'b1, 1'b0);  check_vec("R3 right 3", model(p, 5'd3, 1'b1, 1'b0));
      apply(p, 5'd15, 1'b1, 1'b0); check_vec("R3 right 15", model(p, 5'd15, 1'b1, 1'b0));
   endtask

   task automatic t_bit4_ignored();
      logic [DW-1:0] p;
      p = pattern(29);
      apply(p, 5'd18, 1'b0, 1'b0); check_vec("R1 imm 18 as 2", model(p, 5'd2, 1'b0, 1'b0));
      apply(p, 5'd16, 1'b1, 1'b0); check_vec("R1 imm 16 as 0", p);
   endtask

   task automatic t_lane_isolation();
      logic [DW-1:0] p;
      p = {{16{8'hFF}}, {16{8'hFF}}};
      apply(p, 5'd4, 1'b0, 1'b0);
      check_vec("R4 left no crossing", {{12{8'hFF}}, {4{8'h00}}, {12{8'hFF}}, {4{8'h00}}});
      apply(p, 5'd4, 1'b1, 1'b0);
      check_vec("R4 right no crossing", {{4{8'h00}}, {12{8'hFF}}, {4{8'h00}}, {12{8'hFF}}});
   endtask

   task automatic t_half_boundary();
      logic [DW-1:0] p;
      p = pattern(7);
      apply(p, 5'd8, 1'b0, 1'b0);
      check_vec("R7 left 8", {p[191:128], 64'd0, p[63:0], 64'd0});
      apply(p, 5'd8, 1'b1, 1'b0);
      check_vec("R7 right 8", {64'd0, p[255:192], 64'd0, p[127:64]});
      apply(p, 5'd12, 1'b1, 1'b0);
      check_vec("R7 right 12", {96'd0, p[255:224], 96'd0, p[127:96]});
   endtask

   task automatic t_narrow();
      logic [DW-1:0] p;
      p = pattern(41);
      apply(p, 5'd6, 1'b0, 1'b1); check_vec("R6 narrow left", {128'd0, model(p, 5'd6, 1'b0, 1'b1)});
      apply(p, 5'd0, 1'b1, 1'b1); check_vec("R6 narrow pass", {128'd0, p[127:0]});
   endtask

   task automatic t_decode_concurrent();
      logic [31:0] w;
      logic [DW-1:0] p;
      p = pattern(53);
      w = {16'h768E, 1'b1, 5'd9, 5'd21, 5'd30};
      @(posedge clk);
      insn_word = w; src_vec = p; shamt_imm = 5'd2; shift_right = 1'b0; narrow_mode = 1'b0;
      @(negedge clk);
      check_bit("R8 right form hit", insn_is_bshift, 1'b1);
      check_bit("R8 right dir", insn_right, 1'b1);
      check_bit("R8 imm", insn_imm == 5'd9, 1'b1);
      check_bit("R8 src", insn_src == 5'd21, 1'b1);
      check_bit("R8 dst", insn_dst == 5'd30, 1'b1);
      check_vec("R2 shift independent of word", model(p, 5'd2, 1'b0, 1'b0));
      @(posedge clk); insn_word = {16'h768E, 1'b0, 5'd31, 5'd1, 5'd2};
      @(negedge clk);
      check_bit("R8 left form hit", insn_is_bshift, 1'b1);
      check_bit("R8 left dir", insn_right, 1'b0);
      @(posedge clk); insn_word = {16'h768F, 1'b1, 15'h1234};
      @(negedge clk);
      check_bit("R9 miss hit", insn_is_bshift, 1'b0);
      check_bit("R9 miss dir", insn_right, 1'b0);
      @(posedge clk); insn_word = {16'h368E, 1'b0, 15'h0};
      @(negedge clk);
      check_bit("R9 miss top bit", insn_is_bshift, 1'b0);
   endtask

   task automatic t_sweep();
      logic [DW-1:0] p;
      for (int k = 0; k < 128; k++) begin
         p = pattern(k * 13 + 101);
         apply(p, 5'(k % 32), 1'(k / 32 % 2), 1'(k / 64));
         check_vec("R2 R3 sweep", model(p, 5'(k % 32), 1'(k / 32 % 2), 1'(k / 64)));
      end
   endtask

   initial begin
      t_idle();
      t_zero_shift();
      t_left_right();
      t_bit4_ignored();
      t_lane_isolation();
      t_half_boundary();
      t_narrow();
      t_decode_concurrent();
      t_sweep();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule